// File: doc/BRIEF.md
# UART Receive-Line Wake Qualifier

This always-on block watches the idle-high receive line of a UART while the main receiver is powered down. It requests a wake only after a low level has lasted long enough to count as real traffic. It runs from the low-rate sampling clock, and every rising edge of that clock is one sample. The raw line first passes through a synchronizer. A counter then measures each continuous low run. A run that is too short is logged as a rejected glitch and causes no wake. A run that reaches the qualifying length produces a one-cycle wake pulse.

Two line-driven wake modes are available. Start mode qualifies on a short minimum low, which fits a start bit. Break mode qualifies on a much longer low. Separately, an optional idle timeout can raise a housekeeping wake. After any wake, further wakes are blocked for a programmable number of samples. The cause of the last wake is kept in a reason register until software clears it. Three saturating counters report rejected glitches, wakes, and qualified lows that were blocked by the lockout. Together they give false-wake statistics.

Top module: `uart_wake_qualifier`

## Requirements
- R1: The line is resynchronized through two flops. If `rx_raw` is first low at sampling edge k and stays low, the wake pulse is high in the cycle that follows edge k+Q+2, and never earlier (start mode, no lockout active).
- R2: A low run of fewer than `glitch_len` samples never causes a wake. When the line returns high, `glitch_count` increases by exactly one.
- R3: In start mode, Q = max(`min_low`, `glitch_len`, 1) continuous low samples. A return to high before Q is reached restarts the measurement from zero, so two separate runs shorter than Q cause no wake.
- R4: In break mode (`mode_break`=1), Q uses `break_len` in place of `min_low`. A low shorter than that causes no wake.
- R5: After a wake pulse, qualified lows are ignored for the next `lockout_len` samples. Each ignored qualification increments `suppressed_count` by one.
- R6: With `timeout_len` nonzero and the line held high, timeout wakes repeat every `lockout_len`+`timeout_len`+1 cycles. A value of 0 disables the timeout.
- R7: `wake_pulse` is high for a single cycle, and one continuous low produces at most one pulse.
- R8: `wake_reason` encodes 1 = start-bit low, 2 = break, 3 = timeout, 0 = none. It changes only on a new wake, or returns to 0 on `reason_clr`. A simultaneous wake takes precedence over the clear.
- R9: `wake_count` counts wake pulses. All three counters saturate at all-ones, and `stats_clr` sets all of them to zero.
- R10: During reset, `wake_pulse`, `wake_reason` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-rate sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Asynchronous receive line, idle high |
| mode_break | input | 1 | 0 = start-bit wake, 1 = break wake |
| glitch_len | input | CNT_W | Low runs shorter than this are rejected glitches |
| min_low | input | CNT_W | Qualifying low length in start mode |
| break_len | input | CNT_W | Qualifying low length in break mode |
| lockout_len | input | CNT_W | Samples of retrigger lockout after a wake |
| timeout_len | input | CNT_W | Idle samples before a timeout wake, 0 = off |
| reason_clr | input | 1 | Clears the wake reason |
| stats_clr | input | 1 | Clears all statistics counters |
| wake_pulse | output | 1 | One-cycle wake request |
| wake_reason | output | 2 | Cause of the last wake |
| glitch_count | output | STAT_W | Saturating count of rejected glitches |
| wake_count | output | STAT_W | Saturating count of wakes |
| suppressed_count | output | STAT_W | Saturating count of lockout-blocked qualifications |

## Verification
The embedded properties check several rules on every cycle. No pulse may appear while the lockout is running, and pulses must be single-cycle. Every line-driven wake must be preceded by a low run of at least the qualifying length. A rejected glitch must never coincide with a qualification. The reason may change only on a pulse or a clear, and full counters must hold their value. Other behaviour can only be shown by the bench's scenarios. These include the exact wake latency through the synchronizer, the restart of qualification after a short high, the break-length threshold, the spacing between timeout wakes, and whether random pulse widths land on the correct side of the glitch and qualification limits.

// File: rtl/uwq_pkg.sv
package uwq_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_START   = 2'd1,
    WR_BREAK   = 2'd2,
    WR_TIMEOUT = 2'd3
  } wake_reason_e;
endpackage

// File: rtl/uwq_sync.sv
module uwq_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RESET_VAL;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RESET_VAL;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uwq_low_qualifier.sv
module uwq_low_qualifier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_s,
  input  logic             mode_break,
  input  logic [CNT_W-1:0] glitch_len,
  input  logic [CNT_W-1:0] min_low,
  input  logic [CNT_W-1:0] break_len,
  output logic [CNT_W-1:0] low_run,
  output logic [CNT_W-1:0] thr,
  output logic             glitch_evt,
  output logic             qual_hit
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic hit_taken;

  // Effective threshold: never below the glitch limit, never zero.
  always_comb begin
    thr = mode_break ? break_len : min_low;
    if (glitch_len > thr) thr = glitch_len;
    if (thr == '0)        thr = ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
    end else if (!rx_s) begin
      if (low_run != RUN_MAX) low_run <= low_run + ONE;
    end else begin
      low_run <= '0;
    end
  end

  assign qual_hit   = (low_run == thr) && !hit_taken;
  assign glitch_evt = rx_s && (low_run != '0) && (low_run < glitch_len);

  always_ff @(posedge clk) begin
    if (rst)       hit_taken <= 1'b0;
    else if (rx_s) hit_taken <= 1'b0;
    else if (qual_hit) hit_taken <= 1'b1;
  end

  // R2: a run ending as a glitch never reached qualification
  a_r2_glitch_not_qualified: assert property (@(posedge clk) disable iff (rst)
    glitch_evt |-> !hit_taken);
endmodule

// File: rtl/uwq_wake_ctrl.sv
module uwq_wake_ctrl
  import uwq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_s,
  input  logic             qual_hit,
  input  logic             mode_break,
  input  logic [CNT_W-1:0] lockout_len,
  input  logic [CNT_W-1:0] timeout_len,
  input  logic             reason_clr,
  output logic             wake_pulse,
  output wake_reason_e     wake_reason,
  output logic             suppress_evt
);
  localparam logic [CNT_W-1:0] IDLE_MAX = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] lock_cnt;
  logic [CNT_W-1:0] idle_cnt;
  logic             locked;
  logic             timeout_hit;
  logic             fire;
  wake_reason_e     next_code;

  assign locked       = (lock_cnt != '0);
  assign timeout_hit  = (timeout_len != '0) && (idle_cnt >= timeout_len);
  assign fire         = (qual_hit || timeout_hit) && !locked;
  assign suppress_evt = qual_hit && locked;

  always_comb begin
    if (qual_hit) next_code = mode_break ? WR_BREAK : WR_START;
    else          next_code = WR_TIMEOUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_pulse  <= 1'b0;
      wake_reason <= WR_NONE;
      lock_cnt    <= '0;
      idle_cnt    <= '0;
    end else begin
      wake_pulse <= fire;
      if (fire)            wake_reason <= next_code;
      else if (reason_clr) wake_reason <= WR_NONE;
      if (fire)        lock_cnt <= lockout_len;
      else if (locked) lock_cnt <= lock_cnt - ONE;
      if (fire || locked || !rx_s) idle_cnt <= '0;
      else if (idle_cnt != IDLE_MAX) idle_cnt <= idle_cnt + ONE;
    end
  end

  // R5: no wake while the lockout window is running
  a_r5_lockout_blocks: assert property (@(posedge clk) disable iff (rst)
    locked |=> !wake_pulse);
  // R7: wake request lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  // R8: every pulse carries a cause
  a_r8_reason_on_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (wake_reason != WR_NONE));
  // R8: reason moves only with a wake or a clear
  a_r8_reason_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(wake_reason) |-> (wake_pulse || $past(reason_clr)));
endmodule

// File: rtl/uwq_sat_counter.sv
module uwq_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + ONE;
  end

  // R9: a full counter stays full until cleared
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/uart_wake_qualifier.sv
module uart_wake_qualifier
  import uwq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_raw,
  input  logic              mode_break,
  input  logic [CNT_W-1:0]  glitch_len,
  input  logic [CNT_W-1:0]  min_low,
  input  logic [CNT_W-1:0]  break_len,
  input  logic [CNT_W-1:0]  lockout_len,
  input  logic [CNT_W-1:0]  timeout_len,
  input  logic              reason_clr,
  input  logic              stats_clr,
  output logic              wake_pulse,
  output logic [1:0]        wake_reason,
  output logic [STAT_W-1:0] glitch_count,
  output logic [STAT_W-1:0] wake_count,
  output logic [STAT_W-1:0] suppressed_count
);
  logic             rx_s;
  logic [CNT_W-1:0] q_low_run;
  logic [CNT_W-1:0] q_thr;
  logic             glitch_evt;
  logic             qual_hit;
  logic             suppress_evt;
  wake_reason_e     reason_q;

  uwq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d(rx_raw), .q(rx_s)
  );

  uwq_low_qualifier #(.CNT_W(CNT_W)) i_qual (
    .clk(clk), .rst(rst), .rx_s(rx_s), .mode_break(mode_break),
    .glitch_len(glitch_len), .min_low(min_low), .break_len(break_len),
    .low_run(q_low_run), .thr(q_thr), .glitch_evt(glitch_evt),
    .qual_hit(qual_hit)
  );

  uwq_wake_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .rx_s(rx_s), .qual_hit(qual_hit),
    .mode_break(mode_break), .lockout_len(lockout_len),
    .timeout_len(timeout_len), .reason_clr(reason_clr),
    .wake_pulse(wake_pulse), .wake_reason(reason_q),
    .suppress_evt(suppress_evt)
  );

  assign wake_reason = reason_q;

  uwq_sat_counter #(.W(STAT_W)) i_glitch_cnt (
    .clk(clk), .rst(rst), .clr(stats_clr), .inc(glitch_evt), .cnt(glitch_count)
  );
  uwq_sat_counter #(.W(STAT_W)) i_wake_cnt (
    .clk(clk), .rst(rst), .clr(stats_clr), .inc(wake_pulse), .cnt(wake_count)
  );
  uwq_sat_counter #(.W(STAT_W)) i_supp_cnt (
    .clk(clk), .rst(rst), .clr(stats_clr), .inc(suppress_evt), .cnt(suppressed_count)
  );

  // R3: a line-driven wake follows a low run of the qualifying length
  a_r3_min_low_met: assert property (@(posedge clk) disable iff (rst)
    (wake_pulse && reason_q != WR_TIMEOUT) |-> ($past(q_low_run) >= $past(q_thr)));
endmodule

// File: tb/test_uart_wake_qualifier.sv
module test_uart_wake_qualifier;
  localparam int CNT_W  = 16;
  localparam int STAT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_raw = 1'b1;
  logic mode_break = 1'b0;
  logic [CNT_W-1:0] glitch_len = 16'd3;
  logic [CNT_W-1:0] min_low = 16'd5;
  logic [CNT_W-1:0] break_len = 16'd20;
  logic [CNT_W-1:0] lockout_len = 16'd8;
  logic [CNT_W-1:0] timeout_len = 16'd0;
  logic reason_clr = 1'b0;
  logic stats_clr = 1'b0;
  logic wake_pulse;
  logic [1:0] wake_reason;
  logic [STAT_W-1:0] glitch_count, wake_count, suppressed_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int last_pc = 0;
  int prev_pc = 0;
  bit done = 1'b0;

  uart_wake_qualifier #(.CNT_W(CNT_W), .STAT_W(STAT_W)) i_uart_wake_qualifier (
    .clk(clk), .rst(rst), .rx_raw(rx_raw), .mode_break(mode_break),
    .glitch_len(glitch_len), .min_low(min_low), .break_len(break_len),
    .lockout_len(lockout_len), .timeout_len(timeout_len),
    .reason_clr(reason_clr), .stats_clr(stats_clr),
    .wake_pulse(wake_pulse), .wake_reason(wake_reason),
    .glitch_count(glitch_count), .wake_count(wake_count),
    .suppressed_count(suppressed_count)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wake_pulse) begin
      pulses  = pulses + 1;
      prev_pc = last_pc;
      last_pc = cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_for(input int w);
    rx_raw = 1'b0;
    step(w);
    rx_raw = 1'b1;
  endtask

  function automatic int qual_len(input bit brk, input int mn, input int bk, input int gl);
    int q;
    q = brk ? bk : mn;
    if (gl > q) q = gl;
    if (q == 0) q = 1;
    return q;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, g0, s0, q, w, exp_glitch, exp_wake;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    step(3);
    // R10 reset state
    chk("R10 pulse", int'(wake_pulse), 0);
    chk("R10 reason", int'(wake_reason), 0);
    chk("R10 counters", int'(glitch_count) + int'(wake_count) + int'(suppressed_count), 0);
    rst = 1'b0;
    step(5);

    // R1/R3 latency: Q=5, pulse visible 8 samples after the first low
    q = qual_len(0, 5, 20, 3);
    p0 = pulses;
    rx_raw = 1'b0;
    step(q + 2);
    chk("R1 no early pulse", int'(wake_pulse), 0);
    step(1);
    chk("R1 pulse at Q+3", int'(wake_pulse), 1);
    chk("R8 start reason", int'(wake_reason), 1);
    step(1);
    chk("R7 single cycle", int'(wake_pulse), 0);
    step(20);
    rx_raw = 1'b1;
    step(15);
    chk("R7 one pulse per low", pulses - p0, 1);

    // R2 glitch rejection
    p0 = pulses; g0 = int'(glitch_count);
    low_for(2);
    step(10);
    chk("R2 glitch counted", int'(glitch_count) - g0, 1);
    chk("R2 glitch no wake", pulses - p0, 0);

    // R3 restart after short high
    p0 = pulses; g0 = int'(glitch_count);
    low_for(4);
    step(1);
    low_for(4);
    step(12);
    chk("R3 restart no wake", pulses - p0, 0);
    chk("R3 restart not glitch", int'(glitch_count) - g0, 0);

    // R4 break mode
    mode_break = 1'b1;
    p0 = pulses;
    low_for(10);
    step(12);
    chk("R4 short low no break wake", pulses - p0, 0);
    q = qual_len(1, 5, 20, 3);
    rx_raw = 1'b0;
    step(q + 2);
    chk("R4 no early break pulse", int'(wake_pulse), 0);
    step(1);
    chk("R4 break pulse", int'(wake_pulse), 1);
    chk("R8 break reason", int'(wake_reason), 2);
    step(10);
    rx_raw = 1'b1;
    step(20);
    mode_break = 1'b0;

    // R8 reason hold and clear
    step(5);
    chk("R8 reason held", int'(wake_reason), 2);
    reason_clr = 1'b1;
    step(1);
    reason_clr = 1'b0;
    chk("R8 reason cleared", int'(wake_reason), 0);

    // R5 lockout
    lockout_len = 16'd30;
    p0 = pulses; s0 = int'(suppressed_count);
    low_for(8);
    step(3);
    low_for(8);
    step(5);
    chk("R5 blocked wake", pulses - p0, 1);
    chk("R5 suppressed counted", int'(suppressed_count) - s0, 1);
    step(40);
    low_for(8);
    step(10);
    chk("R5 wake after lockout", pulses - p0, 2);
    lockout_len = 16'd8;
    step(20);

    // R6 timeout wakes with line idle
    lockout_len = 16'd4;
    timeout_len = 16'd15;
    p0 = pulses;
    step(70);
    chk("R6 timeout fired", int'(pulses - p0 >= 2), 1);
    chk("R6 timeout interval", last_pc - prev_pc, 4 + 15 + 1);
    chk("R8 timeout reason", int'(wake_reason), 3);
    timeout_len = 16'd0;
    lockout_len = 16'd8;
    step(20);
    p0 = pulses;
    step(60);
    chk("R6 timeout disabled", pulses - p0, 0);

    // R9 clear and saturation
    stats_clr = 1'b1;
    step(1);
    stats_clr = 1'b0;
    chk("R9 cleared", int'(glitch_count) + int'(wake_count) + int'(suppressed_count), 0);
    for (int i = 0; i < 260; i++) begin
      low_for(1);
      step(3);
    end
    step(4);
    chk("R9 glitch saturates", int'(glitch_count), 255);

    // Random widths against the limits (R2 R3 R9)
    stats_clr = 1'b1;
    step(1);
    stats_clr = 1'b0;
    min_low = 16'd6;
    q = qual_len(0, 6, 20, 3);
    exp_glitch = 0; exp_wake = 0;
    for (int i = 0; i < 40; i++) begin
      w = 1 + int'($urandom % 12);
      p0 = pulses;
      low_for(w);
      step(20);
      if (w >= q) begin
        exp_wake++;
        chk("R3 random qualified wake", pulses - p0, 1);
        chk("R8 random reason", int'(wake_reason), 1);
      end else begin
        if (w < 3) exp_glitch++;
        chk("R2 random short low no wake", pulses - p0, 0);
      end
    end
    chk("R2 random glitch total", int'(glitch_count), exp_glitch);
    chk("R9 random wake total", int'(wake_count), exp_wake);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule